// File: doc/BRIEF.md
# Two-Read Signed Result Byte Port

This block sits between an 8-bit host data bus and a converter's latched 13-bit signed result: a sign bit plus a 12-bit magnitude. The host fetches a result with two read strobes. The first strobe returns the upper magnitude bits, with the sign copied into the spare lines. The second strobe returns the lower eight bits. A byte pointer inside the block chooses which half is returned. The pointer advances when a read strobe is released. It goes back to the upper half whenever a new result is latched.

The same block decodes the host control pins into command pulses: calibration start, conversion start with or without auto-zero, and a hold-edge conversion start. It also decodes a test mode that drives a fixed subset of the data lines. All control pins are active low and are sampled synchronously. Every output is registered, so each output reflects the pins one clock after they are sampled. The data bus is modelled as a value vector plus a per-line output-enable vector, and a line that is not enabled always carries zero.

Top module: `byte_result_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `db_oe`, `db_out` and all command pulses are zero, and the byte pointer selects the upper half.
- R2: When `cs_n` and `rd_n` are both low in a cycle, `db_oe` is all ones in the next cycle. When `cs_n` is high, `db_oe` is zero in the next cycle.
- R3: A read that follows a newly latched result returns the upper half. Lines 0 to 3 carry result bits 8 to 11, and lines 4 to 7 each carry the sign (result bit 12).
- R4: The read after the upper-half read returns result bits 0 to 7 on lines 0 to 7.
- R5: The pointer toggles in the cycle a read ends, which is when `cs_n`/`rd_n` stop being both low. A third read therefore returns the upper half again.
- R6: A `res_valid` pulse latches `res_data` and returns the pointer to the upper half, even when only one byte of the previous result was read.
- R7: With `cs_n` and `cal_n` low while `rd_n` and `sh_n` are high, `test_mode` is 1 in the next cycle. `db_oe` is then 8'b0110_1100 (lines 2, 3, 5, 6), and those lines carry the currently selected byte.
- R8: `cal_start` pulses for one cycle when the condition `cs_n` low and `cal_n` low (test mode excluded) becomes true.
- R9: `conv_start` (`az_n` high) or `conv_az_start` (`az_n` low) pulses for one cycle when the condition `cs_n` low, `wr_n` low and `cal_n` high becomes true.
- R10: `sh_start` pulses for one cycle after `sh_n` rises while `cs_n` is low.
- R11: Every `db_out` line whose `db_oe` bit is 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write / conversion start, active low |
| sh_n | input | 1 | Sample/hold, conversion on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| cal_n | input | 1 | Calibration request, active low |
| az_n | input | 1 | Auto-zero select, low selects auto-zero |
| res_valid | input | 1 | One-cycle pulse: new result ready |
| res_data | input | 13 | Result, bit 12 sign, bits 11..0 magnitude |
| db_out | output | 8 | Data bus value |
| db_oe | output | 8 | Per-line output enable |
| conv_start | output | 1 | Conversion start pulse, no auto-zero |
| conv_az_start | output | 1 | Conversion start pulse with auto-zero |
| sh_start | output | 1 | Hold-edge conversion start pulse |
| cal_start | output | 1 | Calibration start pulse |
| test_mode | output | 1 | Test mode decoded |

## Verification
The bench covers several pointer cases. It reads a result three times in a row, so a pointer that never toggles, or toggles on the falling edge of the strobe, returns the wrong half. It also latches a new result after reading only the upper half, which catches a pointer that is not cleared and would return the low byte first. Negative and positive results with distinct bit patterns expose a sign that is not replicated, or a magnitude nibble that is shifted. Test mode, calibration and a held conversion request are driven back to back, so a wrong enable mask, a calibration pulse that fires in test mode, or a level output in place of a single pulse all differ from the reference model.

// File: rtl/brp_pkg.sv
package brp_pkg;
  // Registered command pulses produced by the decoder
  typedef struct packed {
    logic conv;
    logic conv_az;
    logic sh;
    logic cal;
  } brp_cmd_t;

  localparam brp_cmd_t CMD_IDLE = '{conv: 1'b0, conv_az: 1'b0, sh: 1'b0, cal: 1'b0};
endpackage

// File: rtl/brp_decode.sv
module brp_decode
  import brp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cs_n,
  input  logic     wr_n,
  input  logic     sh_n,
  input  logic     rd_n,
  input  logic     cal_n,
  input  logic     az_n,
  output logic     rd_lvl,
  output logic     test_lvl,
  output brp_cmd_t cmd
);
  logic conv_cond, cal_cond;
  logic conv_prev, cal_prev, sh_prev;

  always_comb begin
    rd_lvl    = !cs_n && !rd_n;
    test_lvl  = !cs_n && !cal_n && rd_n && sh_n;
    cal_cond  = !cs_n && !cal_n && !test_lvl;
    conv_cond = !cs_n && !wr_n && cal_n;
    cmd.conv    = conv_cond && !conv_prev && az_n;
    cmd.conv_az = conv_cond && !conv_prev && !az_n;
    cmd.cal     = cal_cond && !cal_prev;
    cmd.sh      = !cs_n && sh_n && !sh_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conv_prev <= 1'b0;
      cal_prev  <= 1'b0;
      sh_prev   <= 1'b1;
    end else begin
      conv_prev <= conv_cond;
      cal_prev  <= cal_cond;
      sh_prev   <= sh_n;
    end
  end
endmodule

// File: rtl/brp_byte_sel.sv
module brp_byte_sel #(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [MAG_W:0]   res_data,
  input  logic             rd_lvl,
  output logic [BUS_W-1:0] byte_o
);
  localparam int HI_W = MAG_W - BUS_W;

  logic [MAG_W:0]   res_q;
  logic             ptr_lo;
  logic             rd_prev;
  logic [BUS_W-1:0] hi_byte, lo_byte;

  // Upper half: remaining magnitude bits, then sign copies
  for (genvar i = 0; i < BUS_W; i++) begin : g_hi
    if (i < HI_W) begin : g_mag
      assign hi_byte[i] = res_q[BUS_W + i];
    end else begin : g_sgn
      assign hi_byte[i] = res_q[MAG_W];
    end
  end

  assign lo_byte = res_q[BUS_W-1:0];
  assign byte_o  = ptr_lo ? lo_byte : hi_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      ptr_lo  <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      rd_prev <= rd_lvl;
      if (res_valid) begin
        res_q  <= res_data;
        ptr_lo <= 1'b0;
      end else if (rd_prev && !rd_lvl) begin
        ptr_lo <= !ptr_lo;
      end
    end
  end
endmodule

// File: rtl/byte_result_port.sv
module byte_result_port
  import brp_pkg::*;
#(
  parameter int               MAG_W     = 12,
  parameter int               BUS_W     = 8,
  parameter logic [BUS_W-1:0] TEST_MASK = 8'b0110_1100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             sh_n,
  input  logic             rd_n,
  input  logic             cal_n,
  input  logic             az_n,
  input  logic             res_valid,
  input  logic [MAG_W:0]   res_data,
  output logic [BUS_W-1:0] db_out,
  output logic [BUS_W-1:0] db_oe,
  output logic             conv_start,
  output logic             conv_az_start,
  output logic             sh_start,
  output logic             cal_start,
  output logic             test_mode
);
  logic             rd_lvl, test_lvl;
  brp_cmd_t         cmd;
  logic [BUS_W-1:0] sel_byte, oe_next;

  brp_decode u_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .sh_n(sh_n),
    .rd_n(rd_n), .cal_n(cal_n), .az_n(az_n),
    .rd_lvl(rd_lvl), .test_lvl(test_lvl), .cmd(cmd)
  );

  brp_byte_sel #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_sel (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .rd_lvl(rd_lvl), .byte_o(sel_byte)
  );

  always_comb begin
    if (rd_lvl)        oe_next = '1;
    else if (test_lvl) oe_next = TEST_MASK;
    else               oe_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      db_out        <= '0;
      db_oe         <= '0;
      conv_start    <= 1'b0;
      conv_az_start <= 1'b0;
      sh_start      <= 1'b0;
      cal_start     <= 1'b0;
      test_mode     <= 1'b0;
    end else begin
      db_out        <= sel_byte & oe_next;
      db_oe         <= oe_next;
      conv_start    <= cmd.conv;
      conv_az_start <= cmd.conv_az;
      sh_start      <= cmd.sh;
      cal_start     <= cmd.cal;
      test_mode     <= test_lvl;
    end
  end
endmodule

// File: rtl/brp_chk.sv
module brp_chk #(
  parameter int               BUS_W     = 8,
  parameter logic [BUS_W-1:0] TEST_MASK = 8'b0110_1100
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n,
  input logic             rd_n,
  input logic             sh_n,
  input logic [BUS_W-1:0] db_out,
  input logic [BUS_W-1:0] db_oe,
  input logic             conv_start,
  input logic             conv_az_start,
  input logic             sh_start,
  input logic             cal_start,
  input logic             test_mode
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(!cs_n && !rd_n) |-> db_oe == '1);
  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(cs_n) |-> db_oe == '0);
  // R7
  test_mask_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> db_oe == TEST_MASK);
  // R11
  undriven_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (db_out & ~db_oe) == '0);
  // R8
  cal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);
  // R8 R9
  cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conv_start, conv_az_start, cal_start}));
  // R10
  sh_edge_chk: assert property (@(posedge clk) disable iff (rst)
    sh_start |-> live && $past(sh_n) && !$past(cs_n));
endmodule

bind byte_result_port brp_chk #(.BUS_W(BUS_W), .TEST_MASK(TEST_MASK)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .sh_n(sh_n),
  .db_out(db_out), .db_oe(db_oe), .conv_start(conv_start),
  .conv_az_start(conv_az_start), .sh_start(sh_start),
  .cal_start(cal_start), .test_mode(test_mode)
);

// File: tb/byte_result_port_bench.sv
module byte_result_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1, wr_n = 1, sh_n = 1, rd_n = 1, cal_n = 1, az_n = 1;
  logic res_valid = 0;
  logic [12:0] res_data = '0;
  logic [7:0] db_out, db_oe;
  logic conv_start, conv_az_start, sh_start, cal_start, test_mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  byte_result_port u_byte_result_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .sh_n(sh_n), .rd_n(rd_n),
    .cal_n(cal_n), .az_n(az_n), .res_valid(res_valid), .res_data(res_data),
    .db_out(db_out), .db_oe(db_oe), .conv_start(conv_start),
    .conv_az_start(conv_az_start), .sh_start(sh_start),
    .cal_start(cal_start), .test_mode(test_mode)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_res = 0, m_lo = 0, m_prd = 0, m_pconv = 0, m_pcal = 0, m_psh = 1;
  int e_out = 0, e_oe = 0, e_cv = 0, e_cva = 0, e_sh = 0, e_cal = 0, e_tm = 0;
  always @(posedge clk) begin
    int rd, tm, calc, convc, hi, sel;
    if (rst) begin
      m_res = 0; m_lo = 0; m_prd = 0; m_pconv = 0; m_pcal = 0; m_psh = 1;
      e_out = 0; e_oe = 0; e_cv = 0; e_cva = 0; e_sh = 0; e_cal = 0; e_tm = 0;
    end else begin
      rd    = (cs_n == 0 && rd_n == 0);
      tm    = (cs_n == 0 && cal_n == 0 && rd_n == 1 && sh_n == 1);
      calc  = (cs_n == 0 && cal_n == 0 && !tm);
      convc = (cs_n == 0 && wr_n == 0 && cal_n == 1);
      hi    = ((m_res >> 8) & 'hF) | (((m_res >> 12) & 1) ? 'hF0 : 0);
      sel   = m_lo ? (m_res & 'hFF) : hi;
      e_oe  = rd ? 'hFF : (tm ? 'h6C : 0);
      e_out = sel & e_oe;
      e_tm  = tm;
      e_cal = calc && !m_pcal;
      e_cv  = convc && !m_pconv && az_n;
      e_cva = convc && !m_pconv && !az_n;
      e_sh  = (cs_n == 0 && sh_n == 1 && m_psh == 0);
      if (res_valid) begin m_res = res_data; m_lo = 0; end
      else if (m_prd && !rd) m_lo = !m_lo;
      m_prd = rd; m_pcal = calc; m_pconv = convc; m_psh = sh_n;
    end
  end

  always @(negedge clk) if (!done) begin
    check("R2 oe", db_oe, e_oe);
    check("R3 R4 R7 R11 data", db_out, e_out);
    check("R7 test", test_mode, e_tm);
    check("R8 cal", cal_start, e_cal);
    check("R9 conv", conv_start, e_cv);
    check("R9 conv_az", conv_az_start, e_cva);
    check("R10 sh", sh_start, e_sh);
  end

  task automatic load(input logic [12:0] v);
    res_valid = 1; res_data = v;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic do_read(string tag, int exp);
    cs_n = 0; rd_n = 0;
    @(negedge clk);
    check(tag, db_out, exp);
    cs_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe", db_oe, 0);
    check("R1 pulses", {conv_start, conv_az_start, sh_start, cal_start, test_mode}, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after", db_out, 0);

    load(13'h05A3);
    do_read("R3 high positive", 'h05);
    do_read("R4 low positive", 'hA3);
    do_read("R5 third read high", 'h05);
    do_read("R5 fourth read low", 'hA3);

    load(13'h1F00);
    do_read("R3 high negative", 'hFF);
    load(13'h1A5C);
    do_read("R6 high after reload", 'hFA);
    do_read("R4 low negative", 'h5C);

    // Chip select high with read low: no drive
    cs_n = 1; rd_n = 0;
    @(negedge clk);
    check("R2 deselected", db_oe, 0);
    rd_n = 1;
    @(negedge clk);
    // Pointer still at high (no completed read)
    do_read("R5 no toggle when deselected", 'hFA);

    // Test mode
    cs_n = 0; cal_n = 0; rd_n = 1; sh_n = 1;
    @(negedge clk);
    check("R7 mode", test_mode, 1);
    check("R7 mask", db_oe, 'h6C);
    check("R7 data", db_out, 'h5C & 'h6C);
    check("R8 no cal in test", cal_start, 0);
    // Leave test mode into calibration (sh low)
    sh_n = 0;
    @(negedge clk);
    check("R8 cal pulse", cal_start, 1);
    @(negedge clk);
    check("R8 cal single", cal_start, 0);
    cal_n = 1; sh_n = 1;
    @(negedge clk);
    check("R10 sh rise", sh_start, 1);
    @(negedge clk);
    check("R10 sh single", sh_start, 0);

    // Conversion starts
    wr_n = 0; az_n = 1;
    @(negedge clk);
    check("R9 conv", conv_start, 1);
    repeat (2) @(negedge clk);
    check("R9 held no repeat", conv_start, 0);
    wr_n = 1;
    @(negedge clk);
    wr_n = 0; az_n = 0;
    @(negedge clk);
    check("R9 conv az", conv_az_start, 1);
    check("R9 conv az not plain", conv_start, 0);
    wr_n = 1; cs_n = 1; az_n = 1;
    repeat (2) @(negedge clk);

    // Read and new result in the same cycle: pointer stays high
    load(13'h0123);
    cs_n = 0; rd_n = 0;
    @(negedge clk);
    cs_n = 1; rd_n = 1; res_valid = 1; res_data = 13'h0BCD;
    @(negedge clk);
    res_valid = 0;
    do_read("R6 reload wins over toggle", 'h0B);
    do_read("R4 low after reload", 'hCD);

    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    do_read("R1 pointer high after reset", 'h00);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule